// File: doc/BRIEF.md
# Bulk translation entry update sequencer

This block takes update commands for a set of I/O translation entry tables and turns each command into a series of single-entry table writes. There are three command kinds. A put writes one entry. A fill writes the same entry value into a run of consecutive pages. A list copy reads entry values, one per page, from a list held in memory. A 64-bit table identifier picks the target table. The starting bus address is rounded down to a page boundary, and each later write moves up by exactly one page.

Each command kind is checked before any write is issued. The sequence ends at the first write that the table refuses, and the command status then carries the table's own error code. When the command finishes, done pulses for one cycle. In that cycle the status and a progress index are presented, and both stay on the outputs until the next command finishes. The table storage and the address translation path are separate blocks. This block only drives their write port.

Top module: `xlat_upd_seq`

## Requirements
- R1: A command is rejected with status 1 (bad parameter), progress 0 and no table write or memory read when any bit of `cmd_tid[63:32]` is set, when `cmd_tid[31:0]` matches none of the configured table identifiers (defaults 0x00000010 at table index 0 and 0x80000001 at table index 1, carried on `tw_tbl`), or when `cmd_op` is 3. Opcodes: 0 put, 1 fill, 2 list.
- R2: The first write address is `cmd_addr` with its low PAGE_SHIFT bits (default 12) cleared, and each later write address is one page (default 0x1000) above the one before it.
- R3: A list command is rejected with status 1 when `cmd_cnt` exceeds 512, or when `cmd_val` (the list base) has any of its low 12 bits set.
- R4: List element i is read from address `cmd_val + 8*i`. The memory returns the byte at the lowest address in `mr_data[7:0]`, and the element is big-endian, so the value written is `mr_data` with its byte order reversed.
- R5: A list command issues one memory read at a time, and it waits for `mr_ack` before it issues the table write for that element. `mr_req` and `tw_req`, together with their address and data, stay high and unchanged until they are acknowledged.
- R6: A fill command is rejected with status 1 when `cmd_cnt` exceeds NUM_ENTRIES (default 1024). Otherwise it writes `cmd_val` to `cmd_cnt` consecutive pages, and a count equal to NUM_ENTRIES is accepted.
- R7: A put command issues exactly one write of `cmd_val` at the aligned address, whatever the value of `cmd_cnt`.
- R8: When a write is acknowledged with a nonzero `tw_rsp`, no further write is issued, and the command completes with status equal to that `tw_rsp` value. A fully successful command completes with status 0.
- R9: A fill or list command with `cmd_cnt` equal to 0 completes with status 1 and issues no write.
- R10: The progress index is i-1, clamped at 0, where i is the element index at which the sequence stopped. That means count-1 after full success, and the index before the failing element on an error.
- R11: `busy` is high and `cmd_ready` is low from the cycle after acceptance through the `done` cycle. `done` is high for exactly one cycle. A command offered while busy is ignored.
- R12: After reset, `busy`, `done`, `tw_req` and `mr_req` are low, `cmd_ready` is high, and `status` and `prog_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken when valid |
| cmd_op | input | 2 | 0 put, 1 fill, 2 list |
| cmd_tid | input | ADDR_W | Table identifier |
| cmd_addr | input | ADDR_W | Starting bus address |
| cmd_val | input | ADDR_W | Entry value (put/fill) or list base (list) |
| cmd_cnt | input | CNT_W | Page count |
| mr_req | output | 1 | List element read request |
| mr_addr | output | ADDR_W | List element address |
| mr_ack | input | 1 | Read data valid |
| mr_data | input | 64 | Read data, lowest-address byte in bits 7:0 |
| tw_req | output | 1 | Table write request |
| tw_tbl | output | TBL_W | Selected table index |
| tw_addr | output | ADDR_W | Page-aligned bus address |
| tw_data | output | 64 | Entry value to write |
| tw_ack | input | 1 | Write acknowledged |
| tw_rsp | input | 2 | Write result, 0 success |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Completion status |
| prog_idx | output | CNT_W | Progress index |

## Verification
The bench goes after the edges of each validation rule: 512 against 513 list elements, a list base off its 4 KiB alignment by 4 bytes, a fill of exactly the table size against one entry more, and identifiers that differ from a valid one only in the upper half or in one low bit. A checker that used >= instead of >, or compared only 32 identifier bits, would accept or reject the wrong command, and the write log would show it. Errors are injected at the first element and in the middle of a run. A design that kept going past the failure, or that reported i rather than i-1, would show extra logged writes or a wrong progress index. List copies use a slow memory whose data has distinct bytes, so a missed byte swap, a wrong element stride or a write issued before the read data arrived all change the logged values.

// File: rtl/xus_pkg.sv
package xus_pkg;
   typedef enum logic [1:0] {
      OP_PUT  = 2'd0,
      OP_FILL = 2'd1,
      OP_LIST = 2'd2,
      OP_RSVD = 2'd3
   } xus_op_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_FETCH,
      S_WRITE,
      S_DONE
   } xus_state_e;

   localparam logic [1:0] XUS_OK      = 2'd0;
   localparam logic [1:0] XUS_BADPARM = 2'd1;
endpackage

// File: rtl/xus_be_swap.sv
module xus_be_swap #(
   parameter int BYTES = 8
) (
   input  logic [BYTES*8-1:0] din,
   output logic [BYTES*8-1:0] dout
);
   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      assign dout[b*8 +: 8] = din[(BYTES-1-b)*8 +: 8];
   end
endmodule

// File: rtl/xus_cmd_check.sv
module xus_cmd_check
   import xus_pkg::*;
#(
   parameter int ADDR_W      = 64,
   parameter int CNT_W       = 32,
   parameter int NUM_TABLES  = 2,
   parameter logic [NUM_TABLES*32-1:0] TBL_IDS = {32'h8000_0001, 32'h0000_0010},
   parameter int NUM_ENTRIES = 1024,
   parameter int LIST_MAX    = 512,
   parameter int LIST_ALIGN  = 12,
   localparam int TBL_W      = (NUM_TABLES > 1) ? $clog2(NUM_TABLES) : 1
) (
   input  xus_op_e                 op,
   input  logic [ADDR_W-1:0]       tid,
   input  logic [LIST_ALIGN-1:0]   list_lo,
   input  logic [CNT_W-1:0]        cnt,
   output logic                    ok,
   output logic [TBL_W-1:0]        tbl_idx
);
   logic [NUM_TABLES-1:0] hit;
   logic                  hit_any;
   logic                  op_ok;

   for (genvar k = 0; k < NUM_TABLES; k++) begin : g_match
      assign hit[k] = (tid[31:0] == TBL_IDS[k*32 +: 32]);
   end

   always_comb begin
      tbl_idx = '0;
      hit_any = 1'b0;
      for (int k = NUM_TABLES-1; k >= 0; k--) begin
         if (hit[k]) begin
            tbl_idx = TBL_W'(k);
            hit_any = 1'b1;
         end
      end
   end

   always_comb begin
      unique case (op)
         OP_PUT:  op_ok = 1'b1;
         OP_FILL: op_ok = (cnt != '0) && (cnt <= CNT_W'(NUM_ENTRIES));
         OP_LIST: op_ok = (cnt != '0) && (cnt <= CNT_W'(LIST_MAX)) &&
                          (list_lo == '0);
         default: op_ok = 1'b0;
      endcase
   end

   assign ok = hit_any && (tid[ADDR_W-1:32] == '0) && op_ok;
endmodule

// File: rtl/xlat_upd_seq.sv
module xlat_upd_seq
   import xus_pkg::*;
#(
   parameter int ADDR_W      = 64,
   parameter int CNT_W       = 32,
   parameter int PAGE_SHIFT  = 12,
   parameter int NUM_TABLES  = 2,
   parameter logic [NUM_TABLES*32-1:0] TBL_IDS = {32'h8000_0001, 32'h0000_0010},
   parameter int NUM_ENTRIES = 1024,
   parameter int LIST_MAX    = 512,
   parameter int LIST_ALIGN  = 12,
   localparam int TBL_W      = (NUM_TABLES > 1) ? $clog2(NUM_TABLES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_tid,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [ADDR_W-1:0] cmd_val,
   input  logic [CNT_W-1:0]  cmd_cnt,
   output logic              mr_req,
   output logic [ADDR_W-1:0] mr_addr,
   input  logic              mr_ack,
   input  logic [63:0]       mr_data,
   output logic              tw_req,
   output logic [TBL_W-1:0]  tw_tbl,
   output logic [ADDR_W-1:0] tw_addr,
   output logic [63:0]       tw_data,
   input  logic              tw_ack,
   input  logic [1:0]        tw_rsp,
   output logic              busy,
   output logic              done,
   output logic [1:0]        status,
   output logic [CNT_W-1:0]  prog_idx
);
   localparam logic [ADDR_W-1:0] PAGE_SZ   = ADDR_W'(1) << PAGE_SHIFT;
   localparam logic [ADDR_W-1:0] PAGE_MASK = ~(PAGE_SZ - ADDR_W'(1));
   localparam int                ELEM_SH   = 3;

   if (ADDR_W <= 32 || ADDR_W < 64) begin : g_bad_addr_w
      $error("ADDR_W must be at least 64");
   end
   if (CNT_W >= ADDR_W || CNT_W < 10) begin : g_bad_cnt_w
      $error("CNT_W must lie in [10, ADDR_W)");
   end
   if (PAGE_SHIFT < ELEM_SH || PAGE_SHIFT >= ADDR_W) begin : g_bad_page
      $error("PAGE_SHIFT out of range");
   end
   if (NUM_TABLES < 1 || LIST_ALIGN < 1) begin : g_bad_cfg
      $error("NUM_TABLES and LIST_ALIGN must be positive");
   end

   xus_state_e         state_q;
   xus_op_e            op_q;
   logic [TBL_W-1:0]   tbl_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [ADDR_W-1:0]  val_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W-1:0]   idx_q;
   logic [63:0]        ent_q;
   logic [1:0]         status_q;
   logic [CNT_W-1:0]   prog_q;

   logic               chk_ok;
   logic [TBL_W-1:0]   chk_tbl;
   logic [63:0]        swapped;
   logic               accept;
   xus_op_e            cmd_op_e;

   assign cmd_op_e = xus_op_e'(cmd_op);
   assign accept   = cmd_valid && (state_q == S_IDLE);

   xus_cmd_check #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_TABLES(NUM_TABLES),
      .TBL_IDS(TBL_IDS), .NUM_ENTRIES(NUM_ENTRIES),
      .LIST_MAX(LIST_MAX), .LIST_ALIGN(LIST_ALIGN)
   ) u_check (
      .op(cmd_op_e), .tid(cmd_tid), .list_lo(cmd_val[LIST_ALIGN-1:0]),
      .cnt(cmd_cnt), .ok(chk_ok), .tbl_idx(chk_tbl)
   );

   xus_be_swap #(.BYTES(8)) u_swap (.din(mr_data), .dout(swapped));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         op_q     <= OP_PUT;
         tbl_q    <= '0;
         addr_q   <= '0;
         val_q    <= '0;
         cnt_q    <= '0;
         idx_q    <= '0;
         ent_q    <= '0;
         status_q <= XUS_OK;
         prog_q   <= '0;
      end else begin
         unique case (state_q)
            S_IDLE: if (accept) begin
               op_q   <= cmd_op_e;
               tbl_q  <= chk_tbl;
               addr_q <= cmd_addr & PAGE_MASK;
               val_q  <= cmd_val;
               cnt_q  <= (cmd_op_e == OP_PUT) ? CNT_W'(1) : cmd_cnt;
               idx_q  <= '0;
               if (!chk_ok) begin
                  status_q <= XUS_BADPARM;
                  prog_q   <= '0;
                  state_q  <= S_DONE;
               end else begin
                  state_q  <= (cmd_op_e == OP_LIST) ? S_FETCH : S_WRITE;
               end
            end
            S_FETCH: if (mr_ack) begin
               ent_q   <= swapped;
               state_q <= S_WRITE;
            end
            S_WRITE: if (tw_ack) begin
               if (tw_rsp != XUS_OK) begin
                  status_q <= tw_rsp;
                  prog_q   <= (idx_q == '0) ? '0 : idx_q - CNT_W'(1);
                  state_q  <= S_DONE;
               end else if (idx_q + CNT_W'(1) == cnt_q) begin
                  status_q <= XUS_OK;
                  prog_q   <= idx_q;
                  state_q  <= S_DONE;
               end else begin
                  idx_q   <= idx_q + CNT_W'(1);
                  addr_q  <= addr_q + PAGE_SZ;
                  state_q <= (op_q == OP_LIST) ? S_FETCH : S_WRITE;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign mr_req    = (state_q == S_FETCH);
   assign mr_addr   = val_q + ({{(ADDR_W-CNT_W){1'b0}}, idx_q} << ELEM_SH);
   assign tw_req    = (state_q == S_WRITE);
   assign tw_tbl    = tbl_q;
   assign tw_addr   = addr_q;
   assign tw_data   = (op_q == OP_LIST) ? ent_q : val_q;
   assign busy      = (state_q != S_IDLE);
   assign cmd_ready = !busy;
   assign done      = (state_q == S_DONE);
   assign status    = status_q;
   assign prog_idx  = prog_q;

   // R1
   bad_tid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready && (cmd_tid[ADDR_W-1:32] != '0)
      |=> done && (status == XUS_BADPARM) && !tw_req);

   // R2
   page_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tw_req |-> (tw_addr[PAGE_SHIFT-1:0] == '0));

   // R5
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tw_req && !tw_ack |=> tw_req && $stable(tw_addr) && $stable(tw_data));

   // R5
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mr_req && !mr_ack |=> mr_req && $stable(mr_addr));

   // R8
   err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tw_req && tw_ack && (tw_rsp != XUS_OK)
      |=> done && !tw_req && (status == $past(tw_rsp)));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);
endmodule

// File: tb/xlat_upd_seq_tb_top.sv
`timescale 1ns/1ps
module xlat_upd_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [1:0]  cmd_op = 2'd0;
   logic [63:0] cmd_tid = '0, cmd_addr = '0, cmd_val = '0;
   logic [31:0] cmd_cnt = '0;
   logic        mr_req, mr_ack = 1'b0;
   logic [63:0] mr_addr, mr_data = '0;
   logic        tw_req, tw_ack = 1'b0;
   logic [0:0]  tw_tbl;
   logic [63:0] tw_addr, tw_data;
   logic [1:0]  tw_rsp = 2'd0;
   logic        busy, done;
   logic [1:0]  status;
   logic [31:0] prog_idx;

   always #4 clk = ~clk;

   xlat_upd_seq dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_tid(cmd_tid), .cmd_addr(cmd_addr), .cmd_val(cmd_val),
      .cmd_cnt(cmd_cnt), .mr_req(mr_req), .mr_addr(mr_addr), .mr_ack(mr_ack),
      .mr_data(mr_data), .tw_req(tw_req), .tw_tbl(tw_tbl), .tw_addr(tw_addr),
      .tw_data(tw_data), .tw_ack(tw_ack), .tw_rsp(tw_rsp), .busy(busy),
      .done(done), .status(status), .prog_idx(prog_idx)
   );

   int n_chk = 0, n_fail = 0;
   int wr_n = 0, rd_n = 0, fail_at = -1;
   logic [1:0]  fail_code = 2'd0;
   logic [63:0] wr_addr [1024];
   logic [63:0] wr_data [1024];
   logic [0:0]  wr_tbl  [1024];
   logic [63:0] rd_addr [1024];
   logic [1:0]  got_st;
   logic [31:0] got_pi;
   bit          bus_seen_busy;

   function automatic logic [63:0] mem_word(input logic [63:0] a);
      return {32'hA1B2_C3D4, a[31:0] ^ 32'h0F1E_0000};
   endfunction

   function automatic logic [63:0] bswap(input logic [63:0] v);
      logic [63:0] r;
      for (int b = 0; b < 8; b++) r[b*8 +: 8] = v[(7-b)*8 +: 8];
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // responders
   initial begin
      int wdly = 0;
      forever begin
         @(negedge clk);
         if (tw_ack) begin
            tw_ack = 1'b0;
            tw_rsp = 2'd0;
         end else if (tw_req) begin
            if (wdly < 1) wdly++;
            else begin
               wdly = 0;
               if (wr_n < 1024) begin
                  wr_addr[wr_n] = tw_addr;
                  wr_data[wr_n] = tw_data;
                  wr_tbl[wr_n]  = tw_tbl;
               end
               tw_rsp = (wr_n == fail_at) ? fail_code : 2'd0;
               tw_ack = 1'b1;
               wr_n++;
            end
         end
      end
   end

   initial begin
      int rdly = 0;
      forever begin
         @(negedge clk);
         if (mr_ack) begin
            mr_ack = 1'b0;
         end else if (mr_req) begin
            if (tw_req) chk(0, "R5", "read and write together", 1, 0);
            if (rdly < 2) rdly++;
            else begin
               rdly = 0;
               if (rd_n < 1024) rd_addr[rd_n] = mr_addr;
               rd_n++;
               mr_data = mem_word(mr_addr);
               mr_ack  = 1'b1;
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "WDOG", "watchdog expired", 0, 1);
      summary();
   end

   task automatic issue(input logic [1:0] op, input logic [63:0] tid,
                        input logic [63:0] addr, input logic [63:0] val,
                        input logic [31:0] cnt, input bit poke_busy);
      int n = 0;
      wr_n = 0; rd_n = 0;
      bus_seen_busy = 0;
      @(negedge clk);
      cmd_op = op; cmd_tid = tid; cmd_addr = addr; cmd_val = val; cmd_cnt = cnt;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      if (busy && !cmd_ready) bus_seen_busy = 1;
      if (poke_busy && !done) begin
         cmd_op = 2'd0; cmd_tid = 64'h10; cmd_addr = 64'hF000; cmd_val = 64'h77;
         cmd_valid = 1'b1;
         @(negedge clk);
         cmd_valid = 1'b0;
      end
      while (!done && n < 20000) begin
         @(negedge clk);
         n++;
      end
      chk(done, "R11", "done seen", {63'd0, done}, 1);
      got_st = status;
      got_pi = prog_idx;
      @(negedge clk);
      chk(!done && !busy && cmd_ready, "R11", "done one cycle then idle",
          {61'd0, done, busy, cmd_ready}, 64'd1);
      chk(status == got_st && prog_idx == got_pi, "R11", "status held",
          {62'd0, status}, {62'd0, got_st});
   endtask

   task automatic t_reset();
      chk(!busy && !done && !tw_req && !mr_req && cmd_ready, "R12", "idle outputs",
          {59'd0, busy, done, tw_req, mr_req, cmd_ready}, 64'd1);
      chk(status == 0 && prog_idx == 0, "R12", "status/prog zero",
          {30'd0, status, prog_idx}, 0);
   endtask

   task automatic t_put();
      issue(2'd0, 64'h10, 64'h12345, 64'hDEAD_BEEF_0000_0003, 32'd99, 0);
      chk(wr_n == 1, "R7", "put write count", wr_n, 1);
      chk(wr_addr[0] == 64'h12000, "R2", "put aligned addr", wr_addr[0], 64'h12000);
      chk(wr_data[0] == 64'hDEAD_BEEF_0000_0003, "R7", "put data", wr_data[0],
          64'hDEAD_BEEF_0000_0003);
      chk(wr_tbl[0] == 1'b0 && got_st == 0 && got_pi == 0, "R8", "put tbl/status/prog",
          {wr_tbl[0], got_st, got_pi}, 0);
   endtask

   task automatic t_fill();
      bit ok = 1;
      issue(2'd1, 64'h8000_0001, 64'h3007, 64'h5555_0001, 32'd5, 1);
      chk(bus_seen_busy, "R11", "busy while running", {63'd0, bus_seen_busy}, 1);
      chk(wr_n == 5, "R6", "fill write count (busy poke ignored)", wr_n, 5);
      for (int i = 0; i < 5; i++)
         if (wr_addr[i] != 64'h3000 + 64'(i) * 64'h1000 || wr_data[i] != 64'h5555_0001 ||
             wr_tbl[i] != 1'b1) ok = 0;
      chk(ok, "R2", "fill addresses step one page, same data, table 1", wr_addr[4], 64'h7000);
      chk(got_st == 0 && got_pi == 4, "R10", "fill full success progress", got_pi, 4);
      issue(2'd1, 64'h10, 64'h0, 64'h9, 32'd1025, 0);
      chk(got_st == 1 && wr_n == 0, "R6", "fill over table size rejected", {got_st, 32'(wr_n)}, 64'h1_0000_0000);
      issue(2'd1, 64'h10, 64'h0, 64'h9, 32'd1024, 0);
      chk(got_st == 0 && wr_n == 1024 && wr_addr[1023] == 64'h3FF000 && got_pi == 1023,
          "R6", "fill of exactly table size", wr_n, 1024);
   endtask

   task automatic t_ids();
      issue(2'd0, 64'h1_0000_0010, 64'h0, 64'h1, 32'd1, 0);
      chk(got_st == 1 && wr_n == 0 && got_pi == 0, "R1", "upper id bits set", got_st, 1);
      issue(2'd0, 64'h11, 64'h0, 64'h1, 32'd1, 0);
      chk(got_st == 1 && wr_n == 0, "R1", "unknown id", got_st, 1);
      issue(2'd3, 64'h10, 64'h0, 64'h1, 32'd1, 0);
      chk(got_st == 1 && wr_n == 0, "R1", "reserved opcode", got_st, 1);
   endtask

   task automatic t_list();
      bit ok = 1;
      issue(2'd2, 64'h10, 64'h5123, 64'h8000, 32'd3, 0);
      chk(rd_n == 3 && wr_n == 3, "R5", "list reads/writes", {32'(rd_n), 32'(wr_n)}, 64'h3_0000_0003);
      for (int i = 0; i < 3; i++) begin
         logic [63:0] a = 64'h8000 + 64'(i) * 8;
         if (rd_addr[i] != a || wr_data[i] != bswap(mem_word(a)) ||
             wr_addr[i] != 64'h5000 + 64'(i) * 64'h1000) ok = 0;
      end
      chk(ok, "R4", "list element address and byte order", wr_data[0], bswap(mem_word(64'h8000)));
      chk(got_st == 0 && got_pi == 2, "R10", "list progress", got_pi, 2);
      issue(2'd2, 64'h10, 64'h0, 64'h8000, 32'd513, 0);
      chk(got_st == 1 && rd_n == 0 && wr_n == 0, "R3", "list over 512", got_st, 1);
      issue(2'd2, 64'h10, 64'h0, 64'h8004, 32'd2, 0);
      chk(got_st == 1 && rd_n == 0, "R3", "list base misaligned", got_st, 1);
      issue(2'd2, 64'h10, 64'h0, 64'h8000, 32'd512, 0);
      chk(got_st == 0 && wr_n == 512 && rd_addr[511] == 64'h8FF8, "R3", "list of 512",
          wr_n, 512);
   endtask

   task automatic t_zero();
      issue(2'd1, 64'h10, 64'h0, 64'h1, 32'd0, 0);
      chk(got_st == 1 && wr_n == 0, "R9", "zero fill", got_st, 1);
      issue(2'd2, 64'h10, 64'h0, 64'h8000, 32'd0, 0);
      chk(got_st == 1 && wr_n == 0 && rd_n == 0, "R9", "zero list", got_st, 1);
   endtask

   task automatic t_errors();
      fail_at = 3; fail_code = 2'd2;
      issue(2'd1, 64'h10, 64'h20000, 64'h4, 32'd6, 0);
      chk(wr_n == 4 && got_st == 2, "R8", "stop at mid error", wr_n, 4);
      chk(got_pi == 2, "R10", "progress before failing element", got_pi, 2);
      fail_at = 0; fail_code = 2'd3;
      issue(2'd1, 64'h10, 64'h20000, 64'h4, 32'd6, 0);
      chk(wr_n == 1 && got_st == 3 && got_pi == 0, "R8", "stop at first element",
          {32'(wr_n), 30'd0, got_st}, 64'h1_0000_0003);
      fail_at = -1; fail_code = 2'd0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_put();
      t_fill();
      t_ids();
      t_list();
      t_zero();
      t_errors();
      summary();
   end
endmodule